// File: doc/BRIEF.md
# Sequencer Handshake and Reset Register

This block is the single control and status word through which a host processor and an embedded microsequencer coordinate. It holds a hold bit that keeps the sequencer in reset and steers a shared memory window. While the bit is set, the window maps the program store and blocks the data RAM. While it is clear, the sequencer runs and the data RAM is reachable. The reset value of the hold bit is a build-time choice. When the program lives in RAM, the sequencer starts held so that firmware can be loaded. When the program lives in ROM, the sequencer starts running at once.

The word also carries an 8-bit trigger field with split rights. The host can only set trigger bits and the sequencer can only clear them, so neither side can undo the other's handshake by accident. An 8-bit status field is written only by the sequencer. The host starts an operation by raising the run bit. If that start carries a nonzero complex-operation code, trigger bit 0 is set automatically. The lowest status bit is folded back into the host-visible run indication, so the host sees "busy" until the sequencer reports that it is alive.

Top module: `seqctl_reg`

## Requirements
- R1: After reset with the program-RAM option (default), the read word is 0x8000_0000, `seqHold` is 1, `dataRamEn` is 0 and `hostRun` is 1.
- R2: With `runIn` low, a host write stores bit 31 of the write data into the hold bit. A 0 releases the sequencer and enables data RAM. A 1 holds it again and selects the program window. The effect is visible one clock after the write.
- R3: With the program-ROM option (`PROG_IN_RAM` = 0), the hold bit resets to 0, so `seqHold` is 0, `dataRamEn` is 1 and the read word is 0 after reset.
- R4: A host write of 1 in any bit of [7:0] sets that trigger bit. A host write of 0 leaves it unchanged.
- R5: A sequencer write of 0 in any bit of [7:0] clears that trigger bit. A sequencer write of 1 leaves it unchanged.
- R6: When a host set (or an automatic set) and a sequencer clear target the same trigger bit in one cycle, the bit ends up set.
- R7: A `runStart` pulse with a nonzero 3-bit `runOp` sets trigger bit 0. A pulse with `runOp` = 0 changes nothing.
- R8: Bits [15:8] are status, loaded whole from `seqWrData[15:8]` on a sequencer write. Host writes never change them.
- R9: `hostRun` equals `runIn` OR the complement of status bit 8, with no register delay.
- R10: A host write while `runIn` is 1 leaves the hold bit unchanged. Bits [30:16] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Register contents: hold bit 31, status [15:8], triggers [7:0] |
| seqWrEn | input | 1 | Sequencer write strobe |
| seqWrData | input | 32 | Sequencer write data: status [15:8], trigger clear mask [7:0] |
| runIn | input | 1 | Operation run flag from the function control register |
| runStart | input | 1 | One-cycle pulse: host has just set the run flag |
| runOp | input | 3 | Complex-operation code accompanying the run start |
| hostRun | output | 1 | Run indication seen by the host |
| seqHold | output | 1 | Holds the sequencer in reset; also selects the program window |
| dataRamEn | output | 1 | Data RAM accessible to the host |

## Verification
The hardest case to reach is a collision on one trigger bit. The sequencer must clear the bit in the same cycle that the host sets it, or that a run start with a nonzero code sets bit 0. The stimulus table contains rows that drive both write strobes together, and a row that pairs a sequencer clear of bit 0 with an operation start, so each set path meets a concurrent clear. The guard on the hold bit is reached by raising `runIn` before a host write that would otherwise release the sequencer. The ROM build is checked on a second instance before any stimulus reaches it.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
  localparam int DATA_W   = 32;
  localparam int TRIG_W   = 8;
  localparam int STAT_W   = 8;
  localparam int OP_W     = 3;
  localparam int HOLD_BIT = 31;
  localparam int TRIG_LSB = 0;
  localparam int STAT_LSB = TRIG_LSB + TRIG_W;

  // Strobes from the decode logic to the storage datapath.
  typedef struct packed {
    logic              loadHold;
    logic              holdVal;
    logic [TRIG_W-1:0] setMask;
    logic [TRIG_W-1:0] clrMask;
    logic              loadStat;
    logic [STAT_W-1:0] statVal;
  } strobe_t;
endpackage

// File: rtl/seqctl_ctrl.sv
module seqctl_ctrl
  import seqctl_pkg::*;
(
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              seqWrEn,
  input  logic [DATA_W-1:0] seqWrData,
  input  logic              runIn,
  input  logic              runStart,
  input  logic [OP_W-1:0]   runOp,
  output strobe_t           strb
);
  logic              autoSet;
  logic [TRIG_W-1:0] autoMask;
  logic [TRIG_W-1:0] hostMask;
  logic              unusedBits;

  assign autoSet  = runStart && (runOp != '0);
  assign autoMask = {{(TRIG_W-1){1'b0}}, autoSet};
  assign hostMask = hostWrEn ? hostWrData[TRIG_LSB +: TRIG_W] : '0;

  always_comb begin
    // The hold bit may only move while no operation is running.
    strb.loadHold = hostWrEn && !runIn;
    strb.holdVal  = hostWrData[HOLD_BIT];
    // Set paths merge here; set wins over clear inside the datapath.
    strb.setMask  = hostMask | autoMask;
    strb.clrMask  = seqWrEn ? ~seqWrData[TRIG_LSB +: TRIG_W] : '0;
    strb.loadStat = seqWrEn;
    strb.statVal  = seqWrData[STAT_LSB +: STAT_W];
  end

  assign unusedBits = ^{hostWrData[HOLD_BIT-1:TRIG_LSB+TRIG_W],
                        seqWrData[DATA_W-1:STAT_LSB+STAT_W]};
endmodule

// File: rtl/seqctl_dp.sv
module seqctl_dp
  import seqctl_pkg::*;
#(
  parameter bit RESET_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              holdQ,
  output logic [STAT_W-1:0] statQ,
  output logic [DATA_W-1:0] rdWord
);
  logic [TRIG_W-1:0] trigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdQ <= RESET_HOLD;
    else if (strb.loadHold) holdQ <= strb.holdVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              statQ <= '0;
    else if (strb.loadStat) statQ <= strb.statVal;
  end

  p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStat |=> $stable(statQ));

  for (genvar i = 0; i < TRIG_W; i++) begin : gTrig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 trigQ[i] <= 1'b0;
      else if (strb.setMask[i])  trigQ[i] <= 1'b1;
      else if (strb.clrMask[i])  trigQ[i] <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setMask[i] && strb.clrMask[i]) |=> trigQ[i]);
    p_no_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clrMask[i] |=> !$fell(trigQ[i]));
    p_no_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
      !strb.setMask[i] |=> !$rose(trigQ[i]));
  end

  always_comb begin
    rdWord                         = '0;
    rdWord[HOLD_BIT]               = holdQ;
    rdWord[STAT_LSB +: STAT_W]     = statQ;
    rdWord[TRIG_LSB +: TRIG_W]     = trigQ;
  end
endmodule

// File: rtl/seqctl_reg.sv
module seqctl_reg
  import seqctl_pkg::*;
#(
  parameter bit PROG_IN_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              seqWrEn,
  input  logic [DATA_W-1:0] seqWrData,
  input  logic              runIn,
  input  logic              runStart,
  input  logic [OP_W-1:0]   runOp,
  output logic              hostRun,
  output logic              seqHold,
  output logic              dataRamEn
);
  strobe_t           strb;
  logic              holdQ;
  logic [STAT_W-1:0] statQ;

  seqctl_ctrl u_ctrl (
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .seqWrEn   (seqWrEn),
    .seqWrData (seqWrData),
    .runIn     (runIn),
    .runStart  (runStart),
    .runOp     (runOp),
    .strb      (strb)
  );

  seqctl_dp #(.RESET_HOLD(PROG_IN_RAM)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .holdQ (holdQ),
    .statQ (statQ),
    .rdWord(hostRdData)
  );

  assign seqHold   = holdQ;
  assign dataRamEn = !holdQ;
  assign hostRun   = runIn | ~statQ[0];

  p_hold_guard_r10: assert property (@(posedge clk) disable iff (!rstN)
    runIn |=> $stable(seqHold));
  p_auto_trig_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runStart && runOp != '0) |=> hostRdData[TRIG_LSB]);
  p_run_view_r9: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdData[STAT_LSB] |-> hostRun);
  p_host_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seqWrEn |=> $stable(hostRdData[STAT_LSB +: STAT_W]));
endmodule

// File: tb/sim_seqctl_reg.sv
`timescale 1ns/1ps
module sim_seqctl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData, romRdData;
  logic        seqWrEn = 1'b0;
  logic [31:0] seqWrData = '0;
  logic        runIn = 1'b0;
  logic        runStart = 1'b0;
  logic [2:0]  runOp = '0;
  logic        hostRun, seqHold, dataRamEn;
  logic        romRun, romHold, romRamEn;
  int          nChk = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  seqctl_reg u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .seqWrEn(seqWrEn), .seqWrData(seqWrData),
    .runIn(runIn), .runStart(runStart), .runOp(runOp), .hostRun(hostRun),
    .seqHold(seqHold), .dataRamEn(dataRamEn));

  seqctl_reg #(.PROG_IN_RAM(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(romRdData), .seqWrEn(seqWrEn), .seqWrData(seqWrData),
    .runIn(runIn), .runStart(runStart), .runOp(runOp), .hostRun(romRun),
    .seqHold(romHold), .dataRamEn(romRamEn));

  typedef struct packed {
    logic        hw;
    logic [31:0] hd;
    logic        sw;
    logic [31:0] sd;
    logic        ri;
    logic        rs;
    logic [2:0]  op;
    logic [31:0] expRd;
    logic        expRun;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h8000_00A5, 1'b0, 32'h0,         1'b0, 1'b0, 3'd0, 32'h8000_00A5, 1'b1}, // R4 set
    '{1'b0, 32'h0,         1'b1, 32'h0000_0FF0, 1'b0, 1'b0, 3'd0, 32'h8000_0FA0, 1'b0}, // R5 R8
    '{1'b1, 32'h8000_1203, 1'b0, 32'h0,         1'b0, 1'b0, 3'd0, 32'h8000_0FA3, 1'b0}, // R4 R8
    '{1'b1, 32'h8000_0001, 1'b1, 32'h0000_3300, 1'b0, 1'b0, 3'd0, 32'h8000_3301, 1'b0}, // R6
    '{1'b0, 32'h0,         1'b1, 32'h0000_33FE, 1'b0, 1'b1, 3'd5, 32'h8000_3301, 1'b0}, // R7 R6
    '{1'b0, 32'h0,         1'b1, 32'h0000_33FE, 1'b0, 1'b0, 3'd0, 32'h8000_3300, 1'b0}, // R5
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 3'd0, 32'h8000_3300, 1'b0}, // R7
    '{1'b1, 32'h0000_0000, 1'b0, 32'h0,         1'b1, 1'b0, 3'd0, 32'h8000_3300, 1'b1}, // R10
    '{1'b1, 32'h0000_0010, 1'b0, 32'h0,         1'b0, 1'b0, 3'd0, 32'h0000_3310, 1'b0}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hostWrEn = 1'b0; seqWrEn = 1'b0; runStart = 1'b0; runOp = '0;
  endtask

  task automatic hostWrite(input logic [31:0] d);
    hostWrEn = 1'b1; hostWrData = d;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic seqWrite(input logic [31:0] d);
    seqWrEn = 1'b1; seqWrData = d;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: program-RAM build resets held
    chk("R1 read word", hostRdData, 32'h8000_0000);
    chk("R1 seqHold", {31'd0, seqHold}, 32'd1);
    chk("R1 dataRamEn", {31'd0, dataRamEn}, 32'd0);
    chk("R1 hostRun", {31'd0, hostRun}, 32'd1);
    // R3: program-ROM build resets running
    chk("R3 read word", romRdData, 32'h0);
    chk("R3 seqHold", {31'd0, romHold}, 32'd0);
    chk("R3 dataRamEn", {31'd0, romRamEn}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      hostWrEn = TBL[i].hw; hostWrData = TBL[i].hd;
      seqWrEn = TBL[i].sw; seqWrData = TBL[i].sd;
      runIn = TBL[i].ri; runStart = TBL[i].rs; runOp = TBL[i].op;
      @(posedge clk); @(negedge clk);
      chk($sformatf("R4/R5/R6/R7/R8/R10 table row %0d read", i), hostRdData, TBL[i].expRd);
      chk($sformatf("R9 table row %0d hostRun", i), {31'd0, hostRun}, {31'd0, TBL[i].expRun});
      chk($sformatf("R2 table row %0d seqHold", i), {31'd0, seqHold}, {31'd0, TBL[i].expRd[31]});
      chk($sformatf("R2 table row %0d dataRamEn", i), {31'd0, dataRamEn}, {31'd0, ~TBL[i].expRd[31]});
      idle();
    end
    runIn = 1'b0;

    // R2: hold again, then release
    hostWrite(32'h8000_0010);
    chk("R2 re-hold read", hostRdData, 32'h8000_3310);
    chk("R2 re-hold dataRamEn", {31'd0, dataRamEn}, 32'd0);
    hostWrite(32'h0000_0000);
    chk("R2 release seqHold", {31'd0, seqHold}, 32'd0);
    chk("R4 write of zeros keeps triggers", hostRdData, 32'h0000_3310);

    // R9: status bit 8 low forces hostRun with runIn low; R5 ones do not clear
    seqWrite(32'h0000_00FF);
    chk("R9 hostRun from status", {31'd0, hostRun}, 32'd1);
    chk("R5 seq ones no effect", hostRdData, 32'h0000_0010);
    runIn = 1'b1;
    @(negedge clk);
    chk("R9 hostRun from runIn", {31'd0, hostRun}, 32'd1);

    // R10: write while running cannot re-hold
    hostWrite(32'h8000_0000);
    chk("R10 guarded write seqHold", {31'd0, seqHold}, 32'd0);
    chk("R10 guarded write read", hostRdData, 32'h0000_0010);
    runIn = 1'b0;
    @(negedge clk);

    finishRun();
  end
endmodule